// File: doc/BRIEF.md
# Timestamped Spy Buffer

This block records a copy of every word that arrives on one data stream. Each word goes into a circular memory, and beside it the block stores the current value of an event-latency timer. An init-event pulse clears the timer to zero and starts it. The timer stops once every input stream has reported its end-of-event marker for that event. The stored stamps therefore show how far into the event each word arrived. After the event is complete, they also give the total time the event took.

The freeze input selects between two modes. In spy mode the memory keeps overwriting its oldest entries. In freeze mode its contents are held for inspection. A status view gives a host three things: the next write slot, a sticky flag that is set once the pointer has wrapped, and a registered copy of the freeze mode. A single-cycle clear strobe on the status returns the pointer to zero and drops the flag. The freeze copy is read-only. A synchronous read port with one cycle of latency gives access to the stored entries.

Top module: `tspy_buffer`

## Requirements
- R1: Each accepted word (`word_valid` high while `freeze` is low) is written to the entry named by `stat_ptr`. The entry holds the timer stamp in the upper TS_W bits and the word in the lower DATA_W bits. Presenting an address on `rd_addr` returns that entry on `rd_data` after the next clock edge.
- R2: Each accepted word moves `stat_ptr` forward by one. After entry DEPTH-1 the pointer returns to 0.
- R3: `stat_ovf` goes high after the first word is written to entry DEPTH-1. It stays high until a clear.
- R4: While `freeze` is high, words are not written and `stat_ptr` holds its value. Capture continues at the held pointer once `freeze` falls.
- R5: `stat_frozen` shows the value `freeze` had at the previous clock edge.
- R6: A high `stat_clr` sets `stat_ptr` to 0 and `stat_ovf` to 0. If a word is accepted in the same cycle, that word goes to entry 0 and `stat_ptr` becomes 1.
- R7: `init_event` clears the timer and starts it. A word accepted k cycles after the init-event cycle (k ≥ 1) carries stamp k-1.
- R8: The timer stops in the cycle in which every bit of `eoe_in` has been seen high at least once since the last init-event. The bits may arrive in any order and in any cycles. The timer does not advance in that cycle and keeps its value until the next init-event.
- R9: `eoe_in` has no effect while the timer is stopped, and none in a cycle where `init_event` is high. A repeated marker from the same stream counts only once.
- R10: A running timer stops at 2^TS_W-1 and does not wrap.
- R11: After reset, `stat_ptr` is 0, `stat_ovf` and `stat_frozen` are 0, and the timer is stopped at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_event | input | 1 | Start-of-event pulse: clears and starts the timer |
| eoe_in | input | N_STREAMS | Per-stream end-of-event markers |
| word_valid | input | 1 | An input word is present |
| word_data | input | DATA_W | Input word |
| freeze | input | 1 | 1 = hold memory and pointer, 0 = spy |
| stat_clr | input | 1 | Host write strobe that clears pointer and overflow |
| stat_ptr | output | $clog2(DEPTH) | Next write entry |
| stat_ovf | output | 1 | Sticky wrap flag |
| stat_frozen | output | 1 | Registered freeze mode |
| rd_addr | input | $clog2(DEPTH) | Readout address |
| rd_data | output | TS_W+DATA_W | Stored {stamp, word}, one cycle after rd_addr |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a host clear and a word capture. The bench forces this at every pointer position: it advances the pointer to each value in turn and then raises `stat_clr` together with an accepted word. It then expects a pointer of 1, a cleared flag, and that word read back from entry 0. The second pair is an init-event and end-of-event markers. The bench drives all markers high during the init-event cycle and expects the timer to keep running, which it judges from the stamps of the words that follow.

// File: rtl/tspy_pkg.sv
`timescale 1ns/1ps
package tspy_pkg;
  typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_e;
endpackage

// File: rtl/tspy_latency_timer.sv
`timescale 1ns/1ps
module tspy_latency_timer
  import tspy_pkg::*;
#(
  parameter int TS_W      = 16,
  parameter int N_STREAMS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_event,
  input  logic [N_STREAMS-1:0] eoe_in,
  output logic [TS_W-1:0]      stamp,
  output logic                 running,
  output logic                 last_eoe_fire
);
  localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

  function automatic logic [TS_W-1:0] sat_inc(input logic [TS_W-1:0] v);
    return (v == TS_MAX) ? v : v + 1'b1;
  endfunction

  tmr_state_e             st_q;
  logic [TS_W-1:0]        cnt_q;
  logic [N_STREAMS-1:0]   seen_q;
  logic [N_STREAMS-1:0]   seen_nxt;

  assign seen_nxt      = seen_q | eoe_in;
  assign last_eoe_fire = (st_q == TMR_RUN) && !init_event && (&seen_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TMR_IDLE;
      cnt_q  <= '0;
      seen_q <= '0;
    end else if (init_event) begin
      st_q   <= TMR_RUN;
      cnt_q  <= '0;
      seen_q <= '0;
    end else if (st_q == TMR_RUN) begin
      seen_q <= seen_nxt;
      if (&seen_nxt) st_q  <= TMR_IDLE;
      else           cnt_q <= sat_inc(cnt_q);
    end
  end

  assign stamp   = cnt_q;
  assign running = (st_q == TMR_RUN);
endmodule

// File: rtl/tspy_wr_ctrl.sv
`timescale 1ns/1ps
module tspy_wr_ctrl #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_valid,
  input  logic          freeze,
  input  logic          stat_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] ptr,
  output logic          ovf,
  output logic          frozen,
  output logic          wrap_fire
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] ptr_q;
  logic          ovf_q;
  logic          frz_q;

  assign wr_en     = word_valid && !freeze;
  assign wr_addr   = stat_clr ? '0 : ptr_q;
  assign wrap_fire = wr_en && !stat_clr && (ptr_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      frz_q <= 1'b0;
    end else begin
      frz_q <= freeze;
      if (stat_clr) begin
        ptr_q <= wr_en ? AW'(1) : '0;
        ovf_q <= 1'b0;
      end else if (wr_en) begin
        ptr_q <= ptr_next(ptr_q);
        if (wrap_fire) ovf_q <= 1'b1;
      end
    end
  end

  assign ptr    = ptr_q;
  assign ovf    = ovf_q;
  assign frozen = frz_q;
endmodule

// File: rtl/tspy_store.sv
`timescale 1ns/1ps
module tspy_store #(
  parameter int DEPTH = 1024,
  parameter int W     = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tspy_buffer.sv
`timescale 1ns/1ps
module tspy_buffer #(
  parameter int DATA_W    = 32,
  parameter int TS_W      = 16,
  parameter int DEPTH     = 1024,
  parameter int N_STREAMS = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int ENT_W    = TS_W + DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_event,
  input  logic [N_STREAMS-1:0] eoe_in,
  input  logic                 word_valid,
  input  logic [DATA_W-1:0]    word_data,
  input  logic                 freeze,
  input  logic                 stat_clr,
  output logic [AW-1:0]        stat_ptr,
  output logic                 stat_ovf,
  output logic                 stat_frozen,
  input  logic [AW-1:0]        rd_addr,
  output logic [ENT_W-1:0]     rd_data
);
  logic [TS_W-1:0] stamp;
  logic            tmr_running;
  logic            last_eoe_fire;
  logic            cap_fire;
  logic            wrap_fire;
  logic [AW-1:0]   wr_addr;

  tspy_latency_timer #(.TS_W(TS_W), .N_STREAMS(N_STREAMS)) u_timer (
    .clk(clk), .rst_n(rst_n), .init_event(init_event), .eoe_in(eoe_in),
    .stamp(stamp), .running(tmr_running), .last_eoe_fire(last_eoe_fire)
  );

  tspy_wr_ctrl #(.DEPTH(DEPTH)) u_wctl (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .freeze(freeze),
    .stat_clr(stat_clr), .wr_en(cap_fire), .wr_addr(wr_addr),
    .ptr(stat_ptr), .ovf(stat_ovf), .frozen(stat_frozen), .wrap_fire(wrap_fire)
  );

  tspy_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .clk(clk), .we(cap_fire), .waddr(wr_addr), .wdata({stamp, word_data}),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/tspy_checker.sv
`timescale 1ns/1ps
module tspy_checker #(
  parameter int DEPTH = 1024,
  parameter int TS_W  = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_event,
  input logic            word_valid,
  input logic            freeze,
  input logic            stat_clr,
  input logic [AW-1:0]   stat_ptr,
  input logic            stat_ovf,
  input logic            stat_frozen,
  input logic [TS_W-1:0] stamp,
  input logic            tmr_running,
  input logic            last_eoe_fire,
  input logic            cap_fire,
  input logic            wrap_fire
);
  localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};
  localparam logic [AW-1:0]   LAST   = AW'(DEPTH - 1);

  AST_FREEZE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !stat_clr) |=> $stable(stat_ptr)); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !freeze && !stat_clr && stat_ptr != LAST) |=> (stat_ptr == $past(stat_ptr) + 1'b1)); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !freeze && !stat_clr && stat_ptr == LAST) |=> (stat_ptr == '0 && stat_ovf)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovf && !stat_clr) |=> stat_ovf); // R3
  AST_OVF_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_ovf && !wrap_fire) |=> !stat_ovf); // R3
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !cap_fire) |=> (stat_ptr == '0 && !stat_ovf)); // R6
  AST_CLEAR_WITH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && word_valid && !freeze) |=> (stat_ptr == AW'(1) && !stat_ovf)); // R6
  AST_FROZEN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> stat_frozen); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_event |=> (stamp == '0 && tmr_running)); // R7
  AST_STOP_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_eoe_fire |=> (!tmr_running && $stable(stamp))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_running && !init_event) |=> (!tmr_running && $stable(stamp))); // R9
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_running && stamp == TS_MAX && !init_event) |=> (stamp == TS_MAX)); // R10
endmodule

bind tspy_buffer tspy_checker #(.DEPTH(DEPTH), .TS_W(TS_W)) u_tspy_chk (
  .clk(clk), .rst_n(rst_n), .init_event(init_event), .word_valid(word_valid),
  .freeze(freeze), .stat_clr(stat_clr), .stat_ptr(stat_ptr), .stat_ovf(stat_ovf),
  .stat_frozen(stat_frozen), .stamp(stamp), .tmr_running(tmr_running),
  .last_eoe_fire(last_eoe_fire), .cap_fire(cap_fire), .wrap_fire(wrap_fire)
);

// File: tb/tspy_buffer_bench.sv
`timescale 1ns/1ps
module tspy_buffer_bench;
  localparam int DW = 8, TW = 5, DEPTH = 16, NS = 3, AW = 4;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_event = 0, word_valid = 0, freeze = 0, stat_clr = 0;
  logic [NS-1:0] eoe_in = '0;
  logic [DW-1:0] word_data = '0;
  logic [AW-1:0] rd_addr = '0, stat_ptr;
  logic stat_ovf, stat_frozen;
  logic [TW+DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  tspy_buffer #(.DATA_W(DW), .TS_W(TW), .DEPTH(DEPTH), .N_STREAMS(NS)) u_tspy_buffer (
    .clk(clk), .rst_n(rst_n), .init_event(init_event), .eoe_in(eoe_in),
    .word_valid(word_valid), .word_data(word_data), .freeze(freeze),
    .stat_clr(stat_clr), .stat_ptr(stat_ptr), .stat_ovf(stat_ovf),
    .stat_frozen(stat_frozen), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_ptr = 0, m_ovf = 0, m_cnt = 0, m_run = 0, m_seen = 0, m_frz = 0;
  int m_mem [DEPTH];
  bit m_vld [DEPTH];

  task automatic check(int act, int exp, string req, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance the reference state, compare after the edge
  task automatic cyc(bit v, int d, bit fz, bit clr, bit ini, int eoe);
    bit cap;
    @(negedge clk);
    word_valid = v; word_data = DW'(d); freeze = fz; stat_clr = clr;
    init_event = ini; eoe_in = NS'(eoe);
    cap = v && !fz;
    if (cap) begin
      m_mem[clr ? 0 : m_ptr] = m_cnt * (1 << DW) + (d % (1 << DW));
      m_vld[clr ? 0 : m_ptr] = 1;
    end
    if (clr) begin m_ptr = cap ? 1 : 0; m_ovf = 0; end
    else if (cap) begin
      if (m_ptr == DEPTH - 1) m_ovf = 1;
      m_ptr = (m_ptr + 1) % DEPTH;
    end
    if (ini) begin m_cnt = 0; m_run = 1; m_seen = 0; end
    else if (m_run == 1) begin
      m_seen = m_seen | eoe;
      if (m_seen == (1 << NS) - 1) m_run = 0;
      else if (m_cnt < TMAX) m_cnt++;
    end
    m_frz = fz;
    @(posedge clk); #2;
    word_valid = 0; freeze = 0; stat_clr = 0; init_event = 0; eoe_in = '0;
    check(int'(stat_ptr), m_ptr, "R2", "stat_ptr");
    check(int'(stat_ovf), m_ovf, "R3", "stat_ovf");
    check(int'(stat_frozen), m_frz, "R5", "stat_frozen");
  endtask

  task automatic readback(string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); rd_addr = AW'(a);
      @(posedge clk); #2;
      if (m_vld[a]) check(int'(rd_data), m_mem[a], req, $sformatf("entry %0d", a));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_mem[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(int'(stat_ptr), 0, "R11", "stat_ptr");
    check(int'(stat_ovf), 0, "R11", "stat_ovf");
    check(int'(stat_frozen), 0, "R11", "stat_frozen");
    cyc(1, 8'h5A, 0, 0, 0, 0);          // R11 idle timer stamps 0
    cyc(0, 0, 0, 0, 0, 3'b111);         // R9 markers while idle
    // R7 R8 R9: init with markers in same cycle, then staggered markers
    cyc(0, 0, 0, 0, 1, 3'b111);
    for (int k = 1; k <= 12; k++) begin
      int e;
      e = (k == 3 || k == 5) ? 3'b001 : (k == 6) ? 3'b100 : (k == 8) ? 3'b010 : 0;
      cyc(1, 16 + k, 0, 0, 0, e);
    end
    cyc(0, 0, 0, 0, 0, 3'b111);         // R9 after stop
    cyc(1, 99, 0, 0, 0, 0);
    readback("R1 R7 R8");
    // R2 R3 wrap past end
    for (int k = 0; k < DEPTH + 3; k++) cyc(1, 40 + k, 0, 0, 0, 0);
    readback("R2");
    // R4 R5 freeze holds content and pointer
    for (int k = 0; k < 5; k++) cyc(1, 8'hEE, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    readback("R4");
    cyc(1, 8'h77, 0, 0, 0, 0);
    readback("R4");
    // R6 clear at every pointer position, alone and with a capture
    for (int p = 0; p < DEPTH; p++) begin
      cyc(0, 0, 0, 1, 0, 0);
      check(int'(stat_ptr), 0, "R6", "ptr after clear");
      for (int k = 0; k < p; k++) cyc(1, p + k, 0, 0, 0, 0);
      cyc(1, 200 + p, 0, 1, 0, 0);
      check(int'(stat_ptr), 1, "R6", "ptr after clear+capture");
      check(int'(stat_ovf), 0, "R6", "ovf after clear+capture");
    end
    cyc(1, 3, 1, 1, 0, 0);              // R6 clear while frozen
    check(int'(stat_ptr), 0, "R6", "ptr after frozen clear");
    readback("R6");
    // R10 saturation
    cyc(0, 0, 0, 0, 1, 0);
    for (int k = 1; k <= 48; k++) cyc(1, k, 0, 0, 0, 0);
    readback("R10");
    cyc(0, 0, 0, 0, 0, 3'b111);
    cyc(1, 1, 0, 0, 0, 0);
    readback("R10");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule